// File: doc/BRIEF.md
# Return Address Shift Stack

This block holds program-counter return addresses for subroutine calls and interrupt entries. It is a fixed chain of three 10-bit levels and has no stack pointer. A push strobe carries the return address into level 0 and moves every older entry one level deeper. A pop strobe moves every entry one level shallower. The top entry, level 0, is always presented on the output, so a return can take its target PC in the same cycle that it raises the pop strobe.

Calls and interrupts use the push input in exactly the same way. Overflow and underflow are silent. When a push arrives with the chain full, the deepest entry is lost. A pop leaves the deepest level holding its old value, so repeated pops keep returning that value.

When push and pop are raised together, level 0 is replaced by the new address and the deeper levels keep their values. All levels clear to zero on a synchronous, active-high reset.

Top module: `rs_return_stack`

## Requirements
- R1: While `rst` is high at a rising clock edge, every level becomes zero, so `top_o` reads 0 and pops that follow also return 0.
- R2: A push without pop loads `push_addr_i` into level 0 and moves level 0 to level 1 and level 1 to level 2 at the same clock edge. After that edge, `top_o` equals the pushed address.
- R3: When a fourth push arrives without intervening pops, the entry that was written earliest is discarded, and no error of any kind is signalled.
- R4: A pop without push moves level 1 to level 0 and level 2 to level 1. Level 2 keeps its previous value.
- R5: Pops beyond the number of stored entries are accepted silently and keep returning the stale value held in level 2.
- R6: When push and pop are high in the same cycle, level 0 takes `push_addr_i` and levels 1 and 2 are unchanged.
- R7: With neither strobe high, every level holds its value.
- R8: `top_o` always shows level 0, including during the cycle in which `pop_i` is high, before the shift takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_addr_i | input | 10 | Return address to store on a push |
| pop_i | input | 1 | Pop strobe (return or return from interrupt) |
| top_o | output | 10 | Current level 0, the return PC |

## Verification
The bound checker tests the level-by-level motion on every cycle: shifting deeper on a push, the deepest level taking the level above it on overflow, shifting shallower on a pop with level 2 held, the replace-only behaviour when both strobes are high, and full hold when idle.

Some behaviour is only visible across a sequence of cycles, so only the bench scenarios show it. This covers the clearing effect of reset, the order of addresses returned after an overflow, stale data repeating through underflowing pops, and `top_o` being valid in the same cycle as the pop strobe. The bench checks these against its own model under both directed and random strobe mixes.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } rs_op_e;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic   push_i,
  input  logic   pop_i,
  output rs_op_e op_o
);
  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op_o = OP_PUSH;
      2'b01:   op_o = OP_POP;
      2'b11:   op_o = OP_SWAP;
      default: op_o = OP_HOLD;
    endcase
  end
endmodule

// File: rtl/rs_level.sv
module rs_level
  import rs_pkg::*;
#(
  parameter int AW     = 10,
  parameter bit IS_TOP = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  rs_op_e        op_i,
  input  logic [AW-1:0] shallow_i,
  input  logic [AW-1:0] deep_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: q_o <= shallow_i;
        OP_POP:  q_o <= deep_i;
        OP_SWAP: q_o <= IS_TOP ? shallow_i : q_o;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/rs_return_stack.sv
module rs_return_stack
  import rs_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] top_o
);
  localparam int LAST = DEPTH - 1;

  rs_op_e        op;
  logic [AW-1:0] lvl_q [DEPTH];

  rs_ctrl u_ctrl (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [AW-1:0] shallow;
    logic [AW-1:0] deep;
    if (i == 0) begin : g_head
      assign shallow = push_addr_i;
    end else begin : g_body
      assign shallow = lvl_q[i-1];
    end
    if (i == LAST) begin : g_tail
      assign deep = lvl_q[i];
    end else begin : g_mid
      assign deep = lvl_q[i+1];
    end
    rs_level #(.AW(AW), .IS_TOP(i == 0)) u_level (
      .clk       (clk),
      .rst       (rst),
      .op_i      (op),
      .shallow_i (shallow),
      .deep_i    (deep),
      .q_o       (lvl_q[i])
    );
  end

  assign top_o = lvl_q[0];
endmodule

// File: rtl/rs_stack_chk.sv
module rs_stack_chk #(
  parameter int DEPTH = 3,
  parameter int AW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_addr_i,
  input logic [AW-1:0] lvl [DEPTH]
);
  localparam int LAST = DEPTH - 1;

  p_push_head_r2: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> (lvl[0] == $past(push_addr_i)));

  for (genvar i = 1; i < DEPTH; i++) begin : g_shift
    p_push_shift_r2: assert property (@(posedge clk) disable iff (rst)
      (push_i && !pop_i) |=> (lvl[i] == $past(lvl[i-1])));
    p_pop_shift_r4: assert property (@(posedge clk) disable iff (rst)
      (pop_i && !push_i) |=> (lvl[i-1] == $past(lvl[i])));
    p_both_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (push_i && pop_i) |=> $stable(lvl[i]));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_idle
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (!push_i && !pop_i) |=> $stable(lvl[i]));
  end

  p_drop_oldest_r3: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i) |=> (lvl[LAST] == $past(lvl[LAST-1])));

  p_tail_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> $stable(lvl[LAST]));

  p_both_head_r6: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i) |=> (lvl[0] == $past(push_addr_i)));
endmodule

bind rs_return_stack rs_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .push_addr_i (push_addr_i),
  .lvl         (lvl_q)
);

// File: tb/tb_rs_return_stack.sv
module tb_rs_return_stack;
  localparam int D  = 3;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] top_o;

  int runs  = 0;
  int fails = 0;
  logic [D-1:0][AW-1:0] mdl = '0;

  always #10 clk = ~clk;

  rs_return_stack #(.DEPTH(D), .AW(AW)) dut (
    .clk(clk), .rst(rst), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .top_o(top_o)
  );

  function automatic logic [D-1:0][AW-1:0] nxt(logic [D-1:0][AW-1:0] m,
                                               logic pu, logic po, logic [AW-1:0] a);
    logic [D-1:0][AW-1:0] r = m;
    if (pu && po) r[0] = a;
    else if (pu) begin
      for (int i = D-1; i > 0; i--) r[i] = m[i-1];
      r[0] = a;
    end else if (po) begin
      for (int i = 0; i < D-1; i++) r[i] = m[i+1];
    end
    return r;
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic pu, logic po, logic [AW-1:0] a, string req);
    @(negedge clk);
    push_i = pu; pop_i = po; push_addr_i = a;
    #1;
    if (po) chk("R8", top_o, mdl[0]);
    @(posedge clk);
    mdl = nxt(mdl, pu, po, a);
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0;
    chk(req, top_o, mdl[0]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; push_i = 1'b0; pop_i = 1'b0;
    @(posedge clk); mdl = '0;
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    do_reset();
    chk("R1", top_o, '0);
    // R2 and R3: four pushes, the earliest is dropped
    step(1, 0, 10'd1, "R2");
    step(1, 0, 10'd2, "R2");
    step(1, 0, 10'd3, "R2");
    step(1, 0, 10'd4, "R3");
    step(0, 0, 10'd999, "R7");
    step(0, 1, '0, "R4");
    chk("R3", top_o, 10'd3);
    step(0, 1, '0, "R4");
    chk("R3", top_o, 10'd2);
    step(0, 1, '0, "R5");
    chk("R5", top_o, 10'd2);
    step(0, 1, '0, "R5");
    // R6: replace top only
    step(1, 0, 10'd100, "R2");
    step(1, 0, 10'd200, "R2");
    step(1, 1, 10'd300, "R6");
    chk("R6", top_o, 10'd300);
    step(0, 1, '0, "R6");
    chk("R6", top_o, 10'd100);
    // R1: reset mid-run clears deeper levels too
    step(1, 0, 10'd55, "R2");
    do_reset();
    chk("R1", top_o, '0);
    step(0, 1, '0, "R1");
    step(0, 1, '0, "R1");
    // R7 and the random mix
    step(0, 0, 10'h3ff, "R7");
    for (int n = 0; n < 400; n++) begin
      logic [1:0] k = 2'($urandom_range(0, 3));
      step(k[1], k[0], AW'($urandom), "R2");
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule